// File: doc/BRIEF.md
# ADC Sample Decimate-Quantize-Pack Unit

This unit sits between a baseband converter and a word-wide capture buffer. It receives signed 14-bit two's-complement samples, each marked by a valid qualifier, and keeps one valid sample in every six. Each kept sample is cut down to its upper bits, either four or eight of them. The reduced samples are then packed, oldest first, into 32-bit words. Every word that leaves the unit is completely filled, so no transfer into the buffer carries unused bits.

A run-time select picks the 4-bit format, with eight samples per word, or the 8-bit format, with four samples per word. A clear input drops any partly built word and restarts both the decimation phase and the packing phase. A change of the format select does the same. Finished words appear on a 32-bit output together with a one-clock strobe.

Top module: `adc_pack_unit`

## Requirements
- R1: While reset is low and in the first cycle after it is released, word_valid is 0 and word_out is 0. After reset the stored format is the 4-bit format.
- R2: The first valid sample after reset, clear or a format change is kept, and after that every sixth valid sample is kept. A cycle with in_valid low does not advance the decimation count.
- R3: In 4-bit format a kept sample is reduced to in_sample[13:10], which is a truncation that keeps the sign.
- R4: In 8-bit format a kept sample is reduced to in_sample[13:6].
- R5: In 4-bit format eight kept samples form one word, and the k-th of them (k = 0..7, oldest first) occupies bits 4k+3 down to 4k.
- R6: In 8-bit format four kept samples form one word, and the k-th of them (k = 0..3) occupies bits 8k+7 down to 8k.
- R7: word_valid is high for exactly one cycle, the cycle after the clock edge that captures the sample filling the last slot. word_out carries the finished word in that cycle.
- R8: When clear is high at a clock edge, the sample on in_sample at that edge is ignored, the partial word is discarded and both counters return to zero.
- R9: At any clock edge where mode8 differs from its value at the previous edge, the unit behaves exactly as it does for clear.
- R10: Between strobes, word_out holds the last finished word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Restart decimation and packing, drop partial word |
| mode8 | input | 1 | 1 = 8-bit format, 0 = 4-bit format |
| in_valid | input | 1 | in_sample carries a sample this cycle |
| in_sample | input | 14 | Signed two's-complement ADC sample |
| word_out | output | 32 | Last packed word |
| word_valid | output | 1 | One-cycle strobe for a new word |

## Verification
If the decimation counter is out of phase, the wrong samples appear in the very first word after a restart. The bench compares every output bit on every clock, so this shows up at the first strobe. If the slot counter is out of step, the strobe arrives early or late, or a reduced sample lands in the wrong nibble or byte, and this too is visible in the first word. A leftover partial word after clear or a format change corrupts the low slots of the next word. That word follows no later than 48 valid input samples after the restart.

// File: rtl/adc_pack_unit.sv
module adc_pack_unit #(
  parameter int SAMPLE_W = 14,
  parameter int DECIM    = 6,
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 4,
  parameter int WIDE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                mode8,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic [WORD_W-1:0]   word_out,
  output logic                word_valid
);
  localparam int NARROW_SLOTS = WORD_W / NARROW_W;
  localparam int WIDE_SLOTS   = WORD_W / WIDE_W;
  localparam int DCNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int SCNT_W = (NARROW_SLOTS > 1) ? $clog2(NARROW_SLOTS) : 1;

  logic              mode_q;
  logic [DCNT_W-1:0] dcnt;
  logic [SCNT_W-1:0] scnt;
  logic [WORD_W-1:0] acc, acc_nxt;
  logic              restart, take, last;
  logic [SCNT_W-1:0] last_slot;
  logic [NARROW_W-1:0] q_nar;
  logic [WIDE_W-1:0]   q_wide;

  assign restart   = clear | (mode8 != mode_q);
  assign take      = in_valid & ~restart & (dcnt == '0);
  assign last_slot = mode8 ? SCNT_W'(WIDE_SLOTS - 1) : SCNT_W'(NARROW_SLOTS - 1);
  assign last      = (scnt == last_slot);
  assign q_nar     = in_sample[SAMPLE_W-1 -: NARROW_W];
  assign q_wide    = in_sample[SAMPLE_W-1 -: WIDE_W];

  always_comb begin
    acc_nxt = acc;
    if (mode8) acc_nxt[int'(scnt)*WIDE_W +: WIDE_W] = q_wide;
    else       acc_nxt[int'(scnt)*NARROW_W +: NARROW_W] = q_nar;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      dcnt       <= '0;
      scnt       <= '0;
      acc        <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      mode_q     <= mode8;
      word_valid <= 1'b0;
      if (restart) begin
        dcnt <= '0;
        scnt <= '0;
      end else if (in_valid) begin
        dcnt <= (dcnt == DCNT_W'(DECIM - 1)) ? '0 : dcnt + 1'b1;
        if (take) begin
          acc <= acc_nxt;
          if (last) begin
            scnt       <= '0;
            word_out   <= acc_nxt;
            word_valid <= 1'b1;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
      end
    end
  end

  p_decim_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dcnt) < DECIM);
  p_slot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> scnt <= last_slot);
  p_strobe_needs_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(in_valid));
  p_clear_no_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !word_valid);
  p_mode_change_no_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode8 != mode_q) |=> !word_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out));
endmodule

// File: tb/adc_pack_unit_tb_top.sv
module adc_pack_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, mode8 = 1'b0, in_valid = 1'b0;
  logic [13:0] in_sample = '0;
  logic [31:0] word_out;
  logic        word_valid;

  always #2.5 clk = ~clk;

  adc_pack_unit dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .mode8(mode8),
    .in_valid(in_valid), .in_sample(in_sample),
    .word_out(word_out), .word_valid(word_valid)
  );

  int checks = 0, errors = 0;
  int dcount = 0;
  bit pmode = 0;
  int slots[$];
  logic [31:0] exp_word = '0;
  bit exp_valid = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(bit c, bit m, bit v, logic [13:0] s);
    bit rs;
    int per, w;
    rs = c || (m != pmode);
    pmode = m;
    exp_valid = 0;
    per = m ? 4 : 8;
    w   = m ? 8 : 4;
    if (rs) begin
      dcount = 0;
      slots.delete();
    end else if (v) begin
      if (dcount == 0) slots.push_back(m ? int'(s[13:6]) : int'(s[13:10]));
      dcount = (dcount + 1) % 6;
      if (slots.size() == per) begin
        logic [31:0] wd;
        wd = '0;
        foreach (slots[k]) wd = wd | (32'(slots[k]) << (k * w));
        exp_word = wd;
        exp_valid = 1;
        slots.delete();
      end
    end
  endtask

  task automatic step(bit c, bit m, bit v, logic [13:0] s);
    @(negedge clk);
    chk("R7", 32'(word_valid), 32'(exp_valid));
    chk(tag, word_out, exp_word);
    model(c, m, v, s);
    clear = c; mode8 = m; in_valid = v; in_sample = s;
    @(posedge clk);
  endtask

  task automatic run(bit m, int n, int gap_pct);
    for (int i = 0; i < n; i++) begin
      bit v;
      v = ($urandom % 100) >= gap_pct;
      step(0, m, v, 14'($urandom));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", word_out, 32'h0);
    chk("R1", 32'(word_valid), 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    tag = "R5";  run(0, 300, 0);
    step(0, 0, 1, 14'h2000); tag = "R3";
    for (int i = 0; i < 48; i++) step(0, 0, 1, (i % 2) ? 14'h1FFF : 14'h2400);
    tag = "R2";  run(0, 400, 40);
    tag = "R9";  step(0, 1, 1, 14'h3FFF);
    tag = "R6";  run(1, 300, 0);
    tag = "R4";
    for (int i = 0; i < 24; i++) step(0, 1, 1, (i % 2) ? 14'h20C0 : 14'h1F3F);
    tag = "R2";  run(1, 300, 30);
    tag = "R8";
    run(1, 17, 0); step(1, 1, 1, 14'h1234); run(1, 60, 0);
    run(1, 9, 0);  step(0, 0, 1, 14'h0ABC); run(0, 120, 0);
    run(0, 23, 0); step(1, 0, 1, 14'h3ABC); step(1, 0, 1, 14'h3ABC); run(0, 120, 10);
    tag = "R9";  run(0, 13, 0); step(0, 1, 1, 14'h1111); step(0, 0, 1, 14'h2222); run(0, 100, 0);
    tag = "R10"; run(0, 50, 100); run(0, 60, 0);
    step(0, 0, 0, 14'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule